// File: doc/BRIEF.md
# FIFO flag offset register programmer

This block holds the two programmable thresholds used by the almost-empty and almost-full flags of a 72-bit wide FIFO with 32,768 words. Each threshold is a 15-bit offset, and the two offsets are driven continuously to the flag comparators. A host can load the offsets in one of two ways. The first is a serial stream, one bit for each rising edge of a serial clock. The second is a sequence of parallel words on the write port, each word carrying one section of an offset. On the read port the host can walk through the same sections and read them back in either loading method.

Each offset is split into a low section (bits 7:0) and a high section (bits 14:8). The four sections always follow one fixed sequence: empty-low, empty-high, full-low, full-high. The loading method is sampled from a select pin during master reset and stays fixed until the next master reset. The serial stream is sampled into the write clock domain, and the parallel data bus is 72 bits wide. The programming sequence is the same whichever FIFO output mode is in use.

Top module: `ofs_prog`

## Requirements
- R1: While `mrs_n` is low at a `wclk` edge (and at an `rclk` edge for the read side), both offsets are set to 127, the write section pointer, the read section pointer and the serial bit counter are set to 0, and `dout` shows the empty-low section (127).
- R2: In parallel mode (`serial_sel` low at reset), each `wclk` edge with `ld` and `wen` high stores the section selected by the write pointer and then advances the pointer. The order is 0 empty-low, 1 empty-high, 2 full-low, 3 full-high, and the pointer wraps from 3 to 0. A low section takes `din[7:0]`. A high section takes `din[6:0]` into offset bits 14:8. All other `din` bits are ignored.
- R3: In serial mode (`serial_sel` high at reset), each rising edge of `sclk` with `ld` and `sen` high shifts `sdata` into the next bit. Bits 0 to 14 fill the empty offset from bit 0 upward, and bits 15 to 29 fill the full offset from bit 0 upward. After the 30th bit the next bit goes to empty offset bit 0 again.
- R4: The loading method is captured only while `mrs_n` is low. Changes of `serial_sel` after reset do not change the method.
- R5: In serial mode, `ld` with `wen` leaves the offsets unchanged. In parallel mode, serial shifting leaves the offsets unchanged.
- R6: With `ld` low, `wen`, `ren`, `sen` and `sclk` change neither the offsets nor either section pointer.
- R7: In both modes, `dout` shows the section at the read pointer, zero-extended to 72 bits. The high sections show offset bits 14:8 in `dout[6:0]`. Each `rclk` edge with `ld` and `ren` high advances the read pointer in the same order as writes, wrapping from 3 to 0.
- R8: Readback leaves the offsets and the write pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write-side clock; offsets and serial sampling live here |
| rclk | input | 1 | Read-side clock for the readback pointer |
| mrs_n | input | 1 | Master reset, active low, synchronous to each clock |
| serial_sel | input | 1 | Loading method sampled during reset: 1 serial, 0 parallel |
| ld | input | 1 | Selects offset registers instead of FIFO memory |
| wen | input | 1 | Write enable, parallel section store when `ld` is high |
| ren | input | 1 | Read enable, readback pointer step when `ld` is high |
| sen | input | 1 | Serial enable |
| sclk | input | 1 | Serial bit clock, sampled in the `wclk` domain |
| sdata | input | 1 | Serial data bit |
| din | input | 72 | Parallel data input |
| dout | output | 72 | Parallel readback output |
| empty_ofs | output | 15 | Almost-empty offset to the flag logic |
| full_ofs | output | 15 | Almost-full offset to the flag logic |

## Verification
A wrong write pointer shows up at the next parallel store. The word lands in the wrong section, and the offset outputs differ from the expected values one `wclk` edge after that store. A wrong read pointer shows on `dout` as soon as it moves. It is caught on the next readback sweep, which steps through all four sections and back to the first. A serial counter that drifts or wraps at the wrong count spreads the stream across the wrong bits. This is visible on the offsets at the halfway check after 15 bits, and again after a second full 30-bit load.

// File: rtl/ofs_prog_pkg.sv
package ofs_prog_pkg;

  typedef enum logic [1:0] {
    SEC_E_LO = 2'd0,
    SEC_E_HI = 2'd1,
    SEC_F_LO = 2'd2,
    SEC_F_HI = 2'd3
  } sec_sel_e;

  typedef enum logic {
    LOAD_PARALLEL = 1'b0,
    LOAD_SERIAL   = 1'b1
  } load_mode_e;

endpackage

// File: rtl/ofs_serial_front.sv
module ofs_serial_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic sen,
  input  logic ld,
  input  logic sdata,
  output logic shift_pulse,
  output logic shift_bit
);

  localparam int NSIG = 4;

  logic [NSIG-1:0] stage [SYNC_STAGES];
  logic            sclk_last;
  logic [NSIG-1:0] synced;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) stage[g] <= '0;
          else        stage[g] <= {sdata, ld, sen, sclk};
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) stage[g] <= '0;
          else        stage[g] <= stage[g-1];
        end
      end
    end
  endgenerate

  assign synced = stage[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) sclk_last <= 1'b0;
    else        sclk_last <= synced[0];
  end

  // rising serial clock, qualified by serial enable and load
  assign shift_pulse = synced[0] & ~sclk_last & synced[1] & synced[2];
  assign shift_bit   = synced[3];

endmodule

// File: rtl/ofs_store.sv
module ofs_store
  import ofs_prog_pkg::*;
#(
  parameter int OFS_W = 15,
  parameter int SEC_W = 8,
  parameter int DIN_W = 72,
  parameter int DFLT  = 127
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mode_pin,
  input  logic                  ld,
  input  logic                  wen,
  input  logic [DIN_W-1:0]      din,
  input  logic                  shift_pulse,
  input  logic                  shift_bit,
  output logic [2*OFS_W-1:0]    ofs_all,
  output logic                  mode_serial,
  output logic [1:0]            wr_ptr,
  output logic [$clog2(2*OFS_W)-1:0] ser_cnt,
  output logic                  par_wr_evt,
  output logic                  ser_evt
);

  localparam int ALL_W    = 2 * OFS_W;
  localparam int HI_W     = OFS_W - SEC_W;
  localparam int CNT_W    = $clog2(ALL_W);
  localparam int SER_LAST = ALL_W - 1;

  load_mode_e mode_q;

  function automatic logic [1:0] ptr_next(input logic [1:0] p);
    return p + 2'd1;
  endfunction

  function automatic logic [CNT_W-1:0] cnt_next(input logic [CNT_W-1:0] c);
    return (c == CNT_W'(SER_LAST)) ? '0 : c + 1'b1;
  endfunction

  function automatic logic [ALL_W-1:0] put_section(
    input logic [ALL_W-1:0] all,
    input logic [1:0]       p,
    input logic [SEC_W-1:0] sec
  );
    logic [ALL_W-1:0] r;
    int base;
    r    = all;
    base = p[1] ? OFS_W : 0;
    if (!p[0]) r[base +: SEC_W]         = sec;
    else       r[base + SEC_W +: HI_W]  = sec[HI_W-1:0];
    return r;
  endfunction

  assign mode_serial = (mode_q == LOAD_SERIAL);
  assign par_wr_evt  = ld & wen & ~mode_serial;
  assign ser_evt     = shift_pulse & mode_serial;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= load_mode_e'(mode_pin);
      ofs_all <= {OFS_W'(DFLT), OFS_W'(DFLT)};
      wr_ptr  <= 2'd0;
      ser_cnt <= '0;
    end else if (par_wr_evt) begin
      ofs_all <= put_section(ofs_all, wr_ptr, din[SEC_W-1:0]);
      wr_ptr  <= ptr_next(wr_ptr);
    end else if (ser_evt) begin
      ofs_all[ser_cnt] <= shift_bit;
      ser_cnt          <= cnt_next(ser_cnt);
    end
  end

endmodule

// File: rtl/ofs_readback.sv
module ofs_readback
  import ofs_prog_pkg::*;
#(
  parameter int OFS_W  = 15,
  parameter int SEC_W  = 8,
  parameter int DOUT_W = 72
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ld,
  input  logic               ren,
  input  logic [2*OFS_W-1:0] ofs_all,
  output logic [1:0]         rd_ptr,
  output logic [DOUT_W-1:0]  dout
);

  localparam int HI_W = OFS_W - SEC_W;

  function automatic logic [SEC_W-1:0] get_section(
    input logic [2*OFS_W-1:0] all,
    input logic [1:0]         p
  );
    logic [OFS_W-1:0] v;
    v = p[1] ? all[2*OFS_W-1:OFS_W] : all[OFS_W-1:0];
    if (!p[0]) return v[SEC_W-1:0];
    return SEC_W'(v[OFS_W-1:SEC_W]);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)         rd_ptr <= 2'd0;
    else if (ld && ren) rd_ptr <= rd_ptr + 2'd1;
  end

  assign dout = DOUT_W'(get_section(ofs_all, rd_ptr));

endmodule

// File: rtl/ofs_prog.sv
module ofs_prog #(
  parameter int OFS_W       = 15,
  parameter int SEC_W       = 8,
  parameter int BUS_W       = 72,
  parameter int DFLT        = 127,
  parameter int SYNC_STAGES = 2
) (
  input  logic             wclk,
  input  logic             rclk,
  input  logic             mrs_n,
  input  logic             serial_sel,
  input  logic             ld,
  input  logic             wen,
  input  logic             ren,
  input  logic             sen,
  input  logic             sclk,
  input  logic             sdata,
  input  logic [BUS_W-1:0] din,
  output logic [BUS_W-1:0] dout,
  output logic [OFS_W-1:0] empty_ofs,
  output logic [OFS_W-1:0] full_ofs
);

  localparam int ALL_W = 2 * OFS_W;
  localparam int CNT_W = $clog2(ALL_W);

  logic             shift_pulse;
  logic             shift_bit;
  logic [ALL_W-1:0] ofs_all;
  logic             mode_serial;
  logic [1:0]       wr_ptr;
  logic [1:0]       rd_ptr;
  logic [CNT_W-1:0] ser_cnt;
  logic             par_wr_evt;
  logic             ser_evt;

  ofs_serial_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk(wclk), .rst_n(mrs_n), .sclk(sclk), .sen(sen), .ld(ld),
    .sdata(sdata), .shift_pulse(shift_pulse), .shift_bit(shift_bit)
  );

  ofs_store #(.OFS_W(OFS_W), .SEC_W(SEC_W), .DIN_W(BUS_W), .DFLT(DFLT)) u_store (
    .clk(wclk), .rst_n(mrs_n), .mode_pin(serial_sel), .ld(ld), .wen(wen),
    .din(din), .shift_pulse(shift_pulse), .shift_bit(shift_bit),
    .ofs_all(ofs_all), .mode_serial(mode_serial), .wr_ptr(wr_ptr),
    .ser_cnt(ser_cnt), .par_wr_evt(par_wr_evt), .ser_evt(ser_evt)
  );

  ofs_readback #(.OFS_W(OFS_W), .SEC_W(SEC_W), .DOUT_W(BUS_W)) u_rb (
    .clk(rclk), .rst_n(mrs_n), .ld(ld), .ren(ren), .ofs_all(ofs_all),
    .rd_ptr(rd_ptr), .dout(dout)
  );

  assign empty_ofs = ofs_all[OFS_W-1:0];
  assign full_ofs  = ofs_all[ALL_W-1:OFS_W];

endmodule

// File: rtl/ofs_prog_chk.sv
module ofs_prog_chk #(
  parameter int OFS_W = 15,
  parameter int DFLT  = 127
) (
  input logic                        wclk,
  input logic                        rclk,
  input logic                        mrs_n,
  input logic                        ld,
  input logic                        ren,
  input logic [OFS_W-1:0]            empty_ofs,
  input logic [OFS_W-1:0]            full_ofs,
  input logic                        mode_serial,
  input logic [1:0]                  wr_ptr,
  input logic [1:0]                  rd_ptr,
  input logic [$clog2(2*OFS_W)-1:0]  ser_cnt,
  input logic                        par_wr_evt,
  input logic                        ser_evt
);

  localparam int CNT_W = $clog2(2*OFS_W);
  localparam int LAST  = 2*OFS_W - 1;

  logic rst_prev = 1'b0;

  always_ff @(posedge wclk) begin
    if (rst_prev) begin
      assert_reset_defaults_R1: assert (empty_ofs == OFS_W'(DFLT) && full_ofs == OFS_W'(DFLT)
                                        && wr_ptr == 2'd0 && ser_cnt == '0)
        else $error("R1 reset values wrong");
    end
    rst_prev <= !mrs_n;
  end

  assert_wr_ptr_step_R2: assert property (@(posedge wclk) disable iff (!mrs_n)
    par_wr_evt |=> wr_ptr == $past(wr_ptr) + 2'd1);

  assert_ser_cnt_step_R3: assert property (@(posedge wclk) disable iff (!mrs_n)
    ser_evt |=> ser_cnt == (($past(ser_cnt) == CNT_W'(LAST)) ? '0 : $past(ser_cnt) + 1'b1));

  assert_mode_locked_R4: assert property (@(posedge wclk) disable iff (!mrs_n)
    mrs_n |=> $stable(mode_serial));

  assert_serial_no_par_R5: assert property (@(posedge wclk) disable iff (!mrs_n)
    mode_serial |=> $stable(wr_ptr));

  assert_idle_offsets_R6: assert property (@(posedge wclk) disable iff (!mrs_n)
    !(par_wr_evt || ser_evt) |=> ($stable(empty_ofs) && $stable(full_ofs)));

  assert_rd_ptr_hold_R7: assert property (@(posedge rclk) disable iff (!mrs_n)
    !(ld && ren) |=> $stable(rd_ptr));

  assert_rd_ptr_step_R7: assert property (@(posedge rclk) disable iff (!mrs_n)
    (ld && ren) |=> rd_ptr == $past(rd_ptr) + 2'd1);

endmodule

bind ofs_prog ofs_prog_chk #(.OFS_W(OFS_W), .DFLT(DFLT)) u_chk (
  .wclk(wclk), .rclk(rclk), .mrs_n(mrs_n), .ld(ld), .ren(ren),
  .empty_ofs(empty_ofs), .full_ofs(full_ofs), .mode_serial(mode_serial),
  .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .ser_cnt(ser_cnt),
  .par_wr_evt(par_wr_evt), .ser_evt(ser_evt)
);

// File: tb/ofs_prog_bench.sv
module ofs_prog_bench;

  localparam int CLK_PERIOD = 10;
  localparam int W = 72;

  logic wclk = 1'b0, rclk = 1'b0;
  logic mrs_n = 1'b0, serial_sel = 1'b0;
  logic ld = 1'b0, wen = 1'b0, ren = 1'b0, sen = 1'b0, sclk = 1'b0, sdata = 1'b0;
  logic [W-1:0] din = '0;
  logic [W-1:0] dout;
  logic [14:0] empty_ofs, full_ofs;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) wclk = ~wclk;
  always #(CLK_PERIOD/2) rclk = ~rclk;

  ofs_prog u_ofs_prog (
    .wclk(wclk), .rclk(rclk), .mrs_n(mrs_n), .serial_sel(serial_sel),
    .ld(ld), .wen(wen), .ren(ren), .sen(sen), .sclk(sclk), .sdata(sdata),
    .din(din), .dout(dout), .empty_ofs(empty_ofs), .full_ofs(full_ofs)
  );

  function automatic logic [7:0] sec_of(input logic [14:0] e, input logic [14:0] f, input int k);
    logic [14:0] v;
    v = (k >= 2) ? f : e;
    return (k % 2 == 0) ? v[7:0] : {1'b0, v[14:8]};
  endfunction

  task automatic chk(input string req, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic sel);
    @(negedge wclk);
    mrs_n = 1'b0; serial_sel = sel; ld = 0; wen = 0; ren = 0; sen = 0; sclk = 0;
    repeat (3) @(negedge wclk);
    mrs_n = 1'b1; serial_sel = ~sel;
    @(negedge wclk);
  endtask

  task automatic par_write(input logic [7:0] sec);
    ld = 1'b1; wen = 1'b1; din = {64'hFFFF_FFFF_FFFF_FFFF, sec};
    @(negedge wclk);
    wen = 1'b0; ld = 1'b0;
  endtask

  task automatic rd_step;
    ld = 1'b1; ren = 1'b1;
    @(negedge wclk);
    ren = 1'b0; ld = 1'b0;
  endtask

  task automatic ser_bit(input logic b, input logic use_ld);
    ld = use_ld; sen = 1'b1; sdata = b;
    repeat (3) @(negedge wclk);
    sclk = 1'b1;
    repeat (4) @(negedge wclk);
    sclk = 1'b0;
    repeat (3) @(negedge wclk);
    ld = 1'b0; sen = 1'b0;
  endtask

  task automatic rb_sweep(input string req, input logic [14:0] e, input logic [14:0] f);
    for (int k = 0; k < 5; k++) begin
      chk(req, $sformatf("readback section %0d", k % 4), dout, W'(sec_of(e, f, k % 4)));
      rd_step();
    end
    rd_step(); rd_step(); rd_step(); // back to section 0
  endtask

  initial begin
    repeat (200000) @(posedge wclk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [14:0] e, f;
    logic [29:0] v;

    // ---- parallel mode ----
    do_reset(1'b0);
    chk("R1", "empty after reset", W'(empty_ofs), W'(127));
    chk("R1", "full after reset", W'(full_ofs), W'(127));
    chk("R1", "dout after reset", dout, W'(127));
    rb_sweep("R7", 15'd127, 15'd127);

    e = 15'd127; f = 15'd127;
    for (int r = 0; r < 6; r++) begin
      logic [14:0] ne, nf;
      ne = 15'((r * 12345 + 7) ^ (r << 11));
      nf = 15'((r * 2047 + 16'h4000) ^ (r * 3));
      if (r == 4) begin ne = 15'h7FFF; nf = 15'h0000; end
      if (r == 5) begin ne = 15'h0000; nf = 15'h7FFF; end
      par_write(ne[7:0]);                e[7:0]  = ne[7:0];
      chk("R2", "empty low write", W'(empty_ofs), W'(e));
      par_write({1'b1, ne[14:8]});       e[14:8] = ne[14:8];
      chk("R2", "empty high write", W'(empty_ofs), W'(e));
      chk("R2", "full untouched", W'(full_ofs), W'(f));
      par_write(nf[7:0]);                f[7:0]  = nf[7:0];
      chk("R2", "full low write", W'(full_ofs), W'(f));
      par_write({1'b1, nf[14:8]});       f[14:8] = nf[14:8];
      chk("R2", "full high write", W'(full_ofs), W'(f));
      chk("R2", "empty after round", W'(empty_ofs), W'(e));
      rb_sweep("R7", e, f);
      chk("R8", "empty after readback", W'(empty_ofs), W'(e));
      chk("R8", "full after readback", W'(full_ofs), W'(f));
    end

    // R6: ld low, all other controls active
    ld = 1'b0; wen = 1'b1; ren = 1'b1; sen = 1'b1;
    for (int i = 0; i < 6; i++) begin
      sclk = ~sclk; repeat (4) @(negedge wclk);
    end
    wen = 0; ren = 0; sen = 0; sclk = 0;
    repeat (4) @(negedge wclk);
    chk("R6", "empty with ld low", W'(empty_ofs), W'(e));
    chk("R6", "full with ld low", W'(full_ofs), W'(f));
    chk("R6", "read pointer with ld low", dout, W'(sec_of(e, f, 0)));
    par_write(8'h5A); e[7:0] = 8'h5A;
    chk("R6", "write pointer with ld low", W'(empty_ofs), W'(e));
    par_write(e[14:8]); par_write(f[7:0]); par_write(f[14:8]);

    // R5: serial shifting in parallel mode
    for (int i = 0; i < 6; i++) ser_bit(i[0], 1'b1);
    chk("R5", "empty after serial in parallel mode", W'(empty_ofs), W'(e));
    chk("R5", "full after serial in parallel mode", W'(full_ofs), W'(f));
    // R4: serial_sel is now high but mode must remain parallel
    par_write(8'hC3); e[7:0] = 8'hC3;
    chk("R4", "parallel still active after select change", W'(empty_ofs), W'(e));

    // ---- serial mode ----
    do_reset(1'b1);
    chk("R1", "empty after serial reset", W'(empty_ofs), W'(127));
    chk("R1", "full after serial reset", W'(full_ofs), W'(127));
    chk("R1", "dout after serial reset", dout, W'(127));
    for (int pass = 0; pass < 3; pass++) begin
      v = (pass == 0) ? 30'h2AB5_1C3D : (pass == 1) ? 30'h1F0F_3C5A : 30'h3FFF_8000;
      for (int b = 0; b < 30; b++) begin
        ser_bit(v[b], 1'b1);
        if (b == 14) begin
          chk("R3", "empty after 15 bits", W'(empty_ofs), W'(v[14:0]));
          chk("R3", "full after 15 bits", W'(full_ofs), W'(pass == 0 ? 15'd127 : f));
        end
      end
      e = v[14:0]; f = v[29:15];
      chk("R3", "empty after serial load", W'(empty_ofs), W'(e));
      chk("R3", "full after serial load", W'(full_ofs), W'(f));
    end
    // R4: serial_sel low now, serial still active (done above); parallel writes ignored (R5)
    for (int k = 0; k < 4; k++) par_write(8'h00);
    chk("R5", "empty after parallel in serial mode", W'(empty_ofs), W'(e));
    chk("R5", "full after parallel in serial mode", W'(full_ofs), W'(f));
    ser_bit(~e[0], 1'b0);
    chk("R6", "serial bit with ld low", W'(empty_ofs), W'(e));
    rb_sweep("R7", e, f);
    chk("R8", "empty after serial-mode readback", W'(empty_ofs), W'(e));
    ser_bit(~e[0], 1'b1); e[0] = ~e[0];
    chk("R4", "serial still active after select change", W'(empty_ofs), W'(e));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule